// File: doc/BRIEF.md
# Audio DSP Microcode Sequencer

This block steps through the microcode store of a small audio DSP. Each microcode slot is a pair of words. The high word carries the opcode, the result address and operand A. The low word carries operands X and Y. In free-run mode one pulse at the start of a sample period makes the sequencer visit every slot once, in address order, one slot per clock. It then waits for the next pulse. For each slot it presents the fetch address, decodes the fields and raises an issue strobe. A result write strobe goes to the external register file. The arithmetic unit, the register files and the delay memory are outside this block.

The conditional-skip opcode (0xF) tests a condition code against a mask taken from operand Y. When the test passes, the slots that follow are suppressed; operand X gives how many. A 32-bit debug control/status word lets software hold the program and run it one slot at a time from a chosen address. The same word shows the live condition code, keeps the address of the first saturating slot, and requests a reset of the delay-line address counter.

Top module: `dspseq_top`

## Requirements
- R1: For an issued slot, `op` is high word bits 23:20, `res_addr` is high bits 19:10, `opa_addr` is high bits 9:0, `opx_addr` is low bits 19:10 and `opy_addr` is low bits 9:0, all taken from the word pair at `imem_addr`.
- R2: With debug bit 15 clear, a `sample_start` pulse while idle makes the sequencer present slots 0 to PROG_DEPTH-1, one per cycle, starting in the cycle after the pulse. It then stops issuing.
- R3: `sample_start` has no effect while a pass is in progress or while debug bit 15 is set.
- R4: `wr_en` is high only in a cycle where `issue_valid` is high and the opcode is not 0xF, so a suppressed slot or a skip slot writes nothing.
- R5: An issued opcode 0xF passes when (`cc_in` AND opy_addr[4:0]) is nonzero. On a pass, the next opx_addr slots in execution order are not issued. A count that reaches past the end of the pass is cut off there, and each new pass starts with no pending skips.
- R6: Debug bit 15 selects single-step mode, which holds the free-running program. It reads back as written.
- R7: Writing the debug word with bits 15 and 14 both 1 issues exactly the slot at the step address (bits 8:0) in the next cycle. After that the step address reads one higher, wrapping from PROG_DEPTH-1 to 0, and bit 14 reads 0. With bit 15 clear, bit 14 starts nothing.
- R8: Debug bits 13:9 read the current `cc_in`.
- R9: The first `sat_in` during an issued slot sets debug bit 25 and stores that slot address in bits 24:16. Later events change neither field. Writing 1 to bit 25 clears the flag.
- R10: Writing 1 to debug bit 31 pulses `tram_clr` for one cycle in the next cycle. Bit 31 reads 0.
- R11: After reset the debug word reads 0 apart from bits 13:9, and neither `issue_valid` nor `tram_clr` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_start | input | 1 | Start-of-sample pulse |
| imem_addr | output | ADDR_W | Microcode fetch address |
| imem_hi | input | 24 | Decoded bits of the high microcode word |
| imem_lo | input | 20 | Decoded bits of the low microcode word |
| cc_in | input | 5 | Current condition code |
| sat_in | input | 1 | Arithmetic unit saturated on the issued slot |
| dbg_we | input | 1 | Debug word write strobe |
| dbg_wdata | input | 32 | Debug word write data |
| dbg_rdata | output | 32 | Debug word read data |
| issue_valid | output | 1 | Slot at imem_addr is issued this cycle |
| wr_en | output | 1 | Result register write enable |
| op | output | 4 | Decoded opcode |
| res_addr | output | 10 | Result address |
| opa_addr | output | 10 | Operand A address |
| opx_addr | output | 10 | Operand X field |
| opy_addr | output | 10 | Operand Y field |
| tram_clr | output | 1 | Delay-line address counter reset request |

## Verification
The bench builds the sequencer with PROG_DEPTH of 16, so a full free-run pass takes 16 cycles. Many passes then fit in a short run. It also makes the end-of-program cut-off of a long skip easy to reach, because a count of 20 from slot 3 crosses the end. The same depth lets a single step at slot 15 show the step-address wrap to 0. The 4-bit address is narrower than the 9-bit debug fields, so the run also covers zero-extension of those fields.

// File: rtl/dspseq_pkg.sv
package dspseq_pkg;

    localparam int HI_W      = 24;
    localparam int LO_W      = 20;
    localparam int FIELD_W   = 10;
    localparam int CC_W      = 5;
    localparam int DBG_W     = 32;
    localparam int DBG_ADR_W = 9;

    // debug word bit positions (software-visible layout)
    localparam int DBG_TRAM_CLR  = 31;
    localparam int DBG_SAT_FLAG  = 25;
    localparam int DBG_SAT_LSB   = 16;
    localparam int DBG_STEP_MODE = 15;
    localparam int DBG_STEP_GO   = 14;
    localparam int DBG_CC_LSB    = 9;
    localparam int DBG_STEP_LSB  = 0;

    typedef logic [3:0] opcode_t;
    localparam opcode_t OP_SKIP = 4'hF;

    typedef enum logic {SEQ_IDLE, SEQ_RUN} seq_state_t;

    typedef struct packed {
        opcode_t              op;
        logic [FIELD_W-1:0]   res;
        logic [FIELD_W-1:0]   opa;
        logic [FIELD_W-1:0]   opx;
        logic [FIELD_W-1:0]   opy;
    } slot_fields_t;

    function automatic slot_fields_t split_slot(input logic [HI_W-1:0] hi,
                                                input logic [LO_W-1:0] lo);
        slot_fields_t f;
        f.op  = hi[23:20];
        f.res = hi[19:10];
        f.opa = hi[9:0];
        f.opx = lo[19:10];
        f.opy = lo[9:0];
        return f;
    endfunction

endpackage

// File: rtl/dspseq_decode.sv
module dspseq_decode
    import dspseq_pkg::*;
(
    input  logic [HI_W-1:0] hi,
    input  logic [LO_W-1:0] lo,
    output slot_fields_t    fields,
    output logic            is_skip
);
    always_comb begin
        fields  = split_slot(hi, lo);
        is_skip = (fields.op == OP_SKIP);
    end
endmodule

// File: rtl/dspseq_pc.sv
module dspseq_pc
    import dspseq_pkg::*;
#(
    parameter int PROG_DEPTH = 512,
    localparam int ADDR_W    = $clog2(PROG_DEPTH)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sample_start,
    input  logic               step_mode,
    input  logic               step_fire,
    input  logic [ADDR_W-1:0]  step_addr,
    input  logic               is_skip,
    input  logic [CC_W-1:0]    cc,
    input  logic [CC_W-1:0]    skip_mask,
    input  logic [FIELD_W-1:0] skip_count,
    output logic [ADDR_W-1:0]  fetch_addr,
    output logic               slot_active,
    output logic               issue
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(PROG_DEPTH - 1);

    seq_state_t          state;
    logic [ADDR_W-1:0]   pc;
    logic [FIELD_W-1:0]  skip_left;
    logic                skipping;
    logic                pass_start;
    logic                skip_take;

    always_comb begin
        slot_active = step_mode ? step_fire : (state == SEQ_RUN);
        fetch_addr  = step_mode ? step_addr : pc;
        skipping    = (skip_left != '0);
        issue       = slot_active && !skipping;
        pass_start  = !step_mode && (state == SEQ_IDLE) && sample_start;
        skip_take   = issue && is_skip && ((cc & skip_mask) != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= SEQ_IDLE;
            pc        <= '0;
            skip_left <= '0;
        end else begin
            if (step_mode) begin
                state <= SEQ_IDLE;
                pc    <= '0;
            end else if (state == SEQ_IDLE) begin
                if (sample_start) begin
                    state <= SEQ_RUN;
                    pc    <= '0;
                end
            end else if (pc == LAST) begin
                state <= SEQ_IDLE;
                pc    <= '0;
            end else begin
                pc <= pc + 1'b1;
            end

            if (pass_start)
                skip_left <= '0;
            else if (slot_active) begin
                if (skipping)
                    skip_left <= skip_left - 1'b1;
                else if (skip_take)
                    skip_left <= skip_count;
            end
        end
    end

    // R2: the counter never leaves the program
    p_pc_range_r2: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_RUN) |-> (pc <= LAST));

    // R2: a pass ends after the last slot
    p_pass_end_r2: assert property (@(posedge clk) disable iff (rst)
        (!step_mode && state == SEQ_RUN && pc == LAST) |=> (state == SEQ_IDLE));

    // R3: nothing issues while idle in free-run mode
    p_idle_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        (!step_mode && state == SEQ_IDLE) |-> !issue);

    // R5: each suppressed slot consumes one count
    p_skip_count_r5: assert property (@(posedge clk) disable iff (rst)
        (slot_active && skip_left != '0 && !pass_start)
            |=> (skip_left == $past(skip_left) - 1'b1));
endmodule

// File: rtl/dspseq_dbg.sv
module dspseq_dbg
    import dspseq_pkg::*;
#(
    parameter int PROG_DEPTH = 512,
    localparam int ADDR_W    = $clog2(PROG_DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [DBG_W-1:0]  wdata,
    input  logic [CC_W-1:0]   cc,
    input  logic              sat_event,
    input  logic [ADDR_W-1:0] sat_pc,
    output logic [DBG_W-1:0]  rdata,
    output logic              step_mode,
    output logic              step_fire,
    output logic [ADDR_W-1:0] step_addr,
    output logic              tram_clr
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(PROG_DEPTH - 1);

    logic              go;
    logic              sat_flag;
    logic [ADDR_W-1:0] sat_addr;
    logic              sat_clear;

    always_comb begin
        step_fire = step_mode && go;
        sat_clear = we && wdata[DBG_SAT_FLAG];
        rdata = '0;
        rdata[DBG_SAT_FLAG]                   = sat_flag;
        rdata[DBG_SAT_LSB +: DBG_ADR_W]       = DBG_ADR_W'(sat_addr);
        rdata[DBG_STEP_MODE]                  = step_mode;
        rdata[DBG_STEP_GO]                    = go;
        rdata[DBG_CC_LSB +: CC_W]             = cc;
        rdata[DBG_STEP_LSB +: DBG_ADR_W]      = DBG_ADR_W'(step_addr);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            step_mode <= 1'b0;
            go        <= 1'b0;
            step_addr <= '0;
            sat_flag  <= 1'b0;
            sat_addr  <= '0;
            tram_clr  <= 1'b0;
        end else begin
            tram_clr <= we && wdata[DBG_TRAM_CLR];

            if (we) begin
                step_mode <= wdata[DBG_STEP_MODE];
                go        <= wdata[DBG_STEP_GO] && wdata[DBG_STEP_MODE];
                step_addr <= wdata[DBG_STEP_LSB +: ADDR_W];
            end else if (step_fire) begin
                go        <= 1'b0;
                step_addr <= (step_addr == LAST) ? '0 : step_addr + 1'b1;
            end

            if (sat_event && (!sat_flag || sat_clear)) begin
                sat_flag <= 1'b1;
                sat_addr <= sat_pc;
            end else if (sat_clear) begin
                sat_flag <= 1'b0;
            end
        end
    end

    // R9: the captured saturation record is sticky until cleared
    p_sat_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (sat_flag && !sat_clear) |=> (sat_flag && $stable(sat_addr)));

    // R10: the clear request follows a write of bit 31
    p_tram_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        tram_clr |-> $past(we && wdata[DBG_TRAM_CLR]));

    // R7: a step trigger is consumed by exactly one slot
    p_step_once_r7: assert property (@(posedge clk) disable iff (rst)
        (step_fire && !we) |=> !go);
endmodule

// File: rtl/dspseq_top.sv
module dspseq_top
    import dspseq_pkg::*;
#(
    parameter int PROG_DEPTH = 512,
    localparam int ADDR_W    = $clog2(PROG_DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sample_start,
    output logic [ADDR_W-1:0] imem_addr,
    input  logic [23:0]       imem_hi,
    input  logic [19:0]       imem_lo,
    input  logic [4:0]        cc_in,
    input  logic              sat_in,
    input  logic              dbg_we,
    input  logic [31:0]       dbg_wdata,
    output logic [31:0]       dbg_rdata,
    output logic              issue_valid,
    output logic              wr_en,
    output logic [3:0]        op,
    output logic [9:0]        res_addr,
    output logic [9:0]        opa_addr,
    output logic [9:0]        opx_addr,
    output logic [9:0]        opy_addr,
    output logic              tram_clr
);
    slot_fields_t      fields;
    logic              is_skip;
    logic              step_mode;
    logic              step_fire;
    logic [ADDR_W-1:0] step_addr;
    logic              slot_active;
    logic              issue;

    dspseq_decode u_decode (
        .hi      (imem_hi),
        .lo      (imem_lo),
        .fields  (fields),
        .is_skip (is_skip)
    );

    dspseq_pc #(.PROG_DEPTH(PROG_DEPTH)) u_pc (
        .clk          (clk),
        .rst          (rst),
        .sample_start (sample_start),
        .step_mode    (step_mode),
        .step_fire    (step_fire),
        .step_addr    (step_addr),
        .is_skip      (is_skip),
        .cc           (cc_in),
        .skip_mask    (fields.opy[CC_W-1:0]),
        .skip_count   (fields.opx),
        .fetch_addr   (imem_addr),
        .slot_active  (slot_active),
        .issue        (issue)
    );

    dspseq_dbg #(.PROG_DEPTH(PROG_DEPTH)) u_dbg (
        .clk       (clk),
        .rst       (rst),
        .we        (dbg_we),
        .wdata     (dbg_wdata),
        .cc        (cc_in),
        .sat_event (issue && sat_in),
        .sat_pc    (imem_addr),
        .rdata     (dbg_rdata),
        .step_mode (step_mode),
        .step_fire (step_fire),
        .step_addr (step_addr),
        .tram_clr  (tram_clr)
    );

    always_comb begin
        issue_valid = issue;
        wr_en       = issue && !is_skip;
        op          = fields.op;
        res_addr    = fields.res;
        opa_addr    = fields.opa;
        opx_addr    = fields.opx;
        opy_addr    = fields.opy;
    end

    // R6: in step mode a slot only runs on a trigger
    p_step_gate_r6: assert property (@(posedge clk) disable iff (rst)
        (step_mode && !step_fire) |-> !issue_valid);

    // R4: suppressed slots never write
    p_skip_nowrite_r4: assert property (@(posedge clk) disable iff (rst)
        (slot_active && !issue_valid) |-> !wr_en);
endmodule

// File: tb/test_dspseq_top.sv
module test_dspseq_top;
    localparam int DEPTH  = 16;
    localparam int ADDR_W = $clog2(DEPTH);

    logic clk = 1'b0, rst = 1'b1, sample_start = 1'b0;
    logic [ADDR_W-1:0] imem_addr;
    logic [4:0] cc_in = '0;
    logic sat_in, sat_arm = 1'b0;
    logic dbg_we = 1'b0;
    logic [31:0] dbg_wdata = '0, dbg_rdata;
    logic issue_valid, wr_en, tram_clr;
    logic [3:0] op;
    logic [9:0] res_addr, opa_addr, opx_addr, opy_addr;
    logic [31:0] mem_hi [DEPTH];
    logic [31:0] mem_lo [DEPTH];

    int errors = 0, checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    assign sat_in = sat_arm && issue_valid && (imem_addr == 5 || imem_addr == 9);

    dspseq_top #(.PROG_DEPTH(DEPTH)) i_dspseq_top (
        .clk(clk), .rst(rst), .sample_start(sample_start), .imem_addr(imem_addr),
        .imem_hi(mem_hi[imem_addr][23:0]), .imem_lo(mem_lo[imem_addr][19:0]),
        .cc_in(cc_in), .sat_in(sat_in), .dbg_we(dbg_we), .dbg_wdata(dbg_wdata),
        .dbg_rdata(dbg_rdata), .issue_valid(issue_valid), .wr_en(wr_en), .op(op),
        .res_addr(res_addr), .opa_addr(opa_addr), .opx_addr(opx_addr),
        .opy_addr(opy_addr), .tram_clr(tram_clr)
    );

    typedef struct packed {
        logic [4:0] cc;
        logic [9:0] cnt;
        logic [4:0] mask;
        logic [4:0] exp_issue;
    } vec_t;

    localparam vec_t VECS [6] = '{
        vec_t'{5'h01, 10'd2,  5'h01, 5'd14},
        vec_t'{5'h02, 10'd2,  5'h01, 5'd16},
        vec_t'{5'h10, 10'd4,  5'h18, 5'd12},
        vec_t'{5'h1F, 10'd0,  5'h1F, 5'd16},
        vec_t'{5'h03, 10'd20, 5'h02, 5'd4},
        vec_t'{5'h00, 10'd4,  5'h1F, 5'd16}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic load_prog(input logic [9:0] cnt, input logic [4:0] mask);
        for (int a = 0; a < DEPTH; a++) begin
            mem_hi[a] = {8'h5A, 1'b0, 3'(a), 10'(a + 100), 10'(a * 3 + 1)};
            mem_lo[a] = {12'h3C3, 10'(a + 7), 10'(1000 - a)};
        end
        mem_hi[3] = {8'h5A, 4'hF, 10'd200, 10'd9};
        mem_lo[3] = {12'h3C3, cnt, 5'd0, mask};
    endtask

    task automatic dbg_write(input logic [31:0] d);
        dbg_we = 1'b1;
        dbg_wdata = d;
        @(negedge clk);
        dbg_we = 1'b0;
        dbg_wdata = '0;
    endtask

    task automatic run_pass(input bit mid, input logic [9:0] cnt, input bit pass,
                            output int ni, output int nw, output int nbad);
        ni = 0; nw = 0; nbad = 0;
        sample_start = 1'b1;
        @(negedge clk);
        sample_start = 1'b0;
        for (int i = 0; i < DEPTH + 8; i++) begin
            if (mid) sample_start = (i == 5);
            if (wr_en) nw++;
            if (issue_valid) begin
                ni++;
                if (op !== mem_hi[imem_addr][23:20] || res_addr !== mem_hi[imem_addr][19:10] ||
                    opa_addr !== mem_hi[imem_addr][9:0] || opx_addr !== mem_lo[imem_addr][19:10] ||
                    opy_addr !== mem_lo[imem_addr][9:0])
                    nbad++;
                if (pass && imem_addr >= 4 && 32'(imem_addr) < 4 + 32'(cnt))
                    nbad++;
            end
            @(negedge clk);
        end
        sample_start = 1'b0;
    endtask

    initial begin
        #1_500_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int ni, nw, nbad;
        load_prog(10'd0, 5'd0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11: reset state
        check("R11 dbg after reset", dbg_rdata, 32'h0);
        check("R11 issue after reset", {31'b0, issue_valid}, 32'h0);
        check("R11 tram_clr after reset", {31'b0, tram_clr}, 32'h0);

        // R1 R2 R4 R5: vector table of skip scenarios
        foreach (VECS[k]) begin
            load_prog(VECS[k].cnt, VECS[k].mask);
            cc_in = VECS[k].cc;
            run_pass(1'b0, VECS[k].cnt, (VECS[k].cc & VECS[k].mask) != 0, ni, nw, nbad);
            check($sformatf("R2 R5 issue count vec%0d", k), ni, VECS[k].exp_issue);
            check($sformatf("R4 write count vec%0d", k), nw, VECS[k].exp_issue - 1);
            check($sformatf("R1 R5 decode and skip window vec%0d", k), nbad, 0);
        end

        // R3: mid-pass start pulse ignored
        load_prog(10'd0, 5'd0);
        cc_in = 5'h00;
        run_pass(1'b1, 10'd0, 1'b0, ni, nw, nbad);
        check("R3 mid-pass start ignored", ni, DEPTH);

        // R8: condition code visible
        cc_in = 5'h15;
        @(negedge clk);
        check("R8 cc field", {27'b0, dbg_rdata[13:9]}, 32'h15);
        cc_in = 5'h00;

        // R9: saturation capture
        sat_arm = 1'b1;
        run_pass(1'b0, 10'd0, 1'b0, ni, nw, nbad);
        sat_arm = 1'b0;
        check("R9 sat flag set", {31'b0, dbg_rdata[25]}, 32'h1);
        check("R9 first sat address", {23'b0, dbg_rdata[24:16]}, 32'h5);
        dbg_write(32'h0200_0000);
        check("R9 sat flag cleared", {31'b0, dbg_rdata[25]}, 32'h0);
        run_pass(1'b0, 10'd0, 1'b0, ni, nw, nbad);
        check("R9 flag stays clear", {31'b0, dbg_rdata[25]}, 32'h0);

        // R10: delay-line counter reset request
        dbg_write(32'h8000_0000);
        check("R10 pulse high", {31'b0, tram_clr}, 32'h1);
        check("R10 bit31 reads 0", {31'b0, dbg_rdata[31]}, 32'h0);
        @(negedge clk);
        check("R10 pulse one cycle", {31'b0, tram_clr}, 32'h0);

        // R6 R7: single-step
        dbg_write(32'h0000_8007);
        check("R6 mode bit reads back", {31'b0, dbg_rdata[15]}, 32'h1);
        check("R6 no issue without trigger", {31'b0, issue_valid}, 32'h0);
        dbg_write(32'h0000_C007);
        check("R7 step issues", {31'b0, issue_valid}, 32'h1);
        check("R7 step address used", {28'b0, imem_addr}, 32'h7);
        check("R7 R1 step decode X", {22'b0, opx_addr}, 32'd14);
        @(negedge clk);
        check("R7 single slot only", {31'b0, issue_valid}, 32'h0);
        check("R7 step addr advanced", {23'b0, dbg_rdata[8:0]}, 32'h8);
        check("R7 trigger cleared", {31'b0, dbg_rdata[14]}, 32'h0);
        dbg_write(32'h0000_C00F);
        check("R7 step at last slot", {28'b0, imem_addr}, 32'hF);
        @(negedge clk);
        check("R7 step addr wraps", {23'b0, dbg_rdata[8:0]}, 32'h0);

        // R3 R6: start pulse ignored in step mode
        run_pass(1'b0, 10'd0, 1'b0, ni, nw, nbad);
        check("R3 start ignored in step mode", ni, 0);

        // R7: trigger without step mode does nothing
        dbg_write(32'h0000_4003);
        check("R7 trigger needs mode", {31'b0, issue_valid}, 32'h0);
        check("R7 trigger not held", {31'b0, dbg_rdata[14]}, 32'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule